// File: doc/BRIEF.md
# Shared-Logic Carry Select Adder

This block adds two N-bit operands and a carry-in and produces an N-bit sum and a carry-out, with no clock and no state. The operands are cut into groups of G bits. Each group works out two candidate results side by side. One assumes the carry entering the group is 0 and the other assumes it is 1. When the real carry arrives, a 2:1 selector keeps one candidate sum and one candidate carry-out.

The group does not hold two ripple-carry copies. Each bit cell derives one half-sum and one half-carry from its operand bits, and from those two terms it gives a candidate pair for each carry case. Assuming carry-in 0, the sum bit is the half-sum and the carry is the AND of the operands. Assuming carry-in 1, the sum bit is the inverted half-sum and the carry is the OR of the operands. Inside a group, two carry chains pick through these pairs bit by bit. Across the groups, the carry-in drives the first selector and each chosen carry-out drives the next one.

Top module: `csa_adder`

## Requirements
- R1: For every input, {cout_o, sum_o} equals a_i + b_i + cin_i, computed as an unsigned (N+1)-bit value.
- R2: For the same operands, the result with cin_i = 1 is exactly one greater than the result with cin_i = 0, taken over the (N+1)-bit value {cout_o, sum_o}.
- R3: cout_o is 1 exactly when a_i + b_i + cin_i is 2^N or more, and 0 otherwise.
- R4: For each bit cell, the candidate for carry-in 0 is (sum = a xor b, carry = a and b) and the candidate for carry-in 1 is (sum = not(a xor b), carry = a or b). At N = G = 1 the ports therefore give sum = a xor b xor cin and carry = majority(a, b, cin), and the two sums for cin 0 and cin 1 are each other's inverse.
- R5: Each group gives a carry-0 candidate equal to its operand slices added with carry 0, and a carry-1 candidate equal to the same slices added with carry 1. The carry-1 candidate's carry-out is never below the carry-0 candidate's carry-out.
- R6: A carry crosses every group boundary. 0xFF + 0x00 + 1 gives sum 0x00 with cout 1, and 0x0F + 0x01 + 0 gives 0x10 with cout 0.
- R7: The result of R1 holds for any N that is a multiple of G, including G = 1, G = N and groups of 3 bits. A width that G does not divide stops elaboration.
- R8: The outputs depend only on the present inputs and are valid in the same time step as the inputs, with no clock cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand, unsigned |
| b_i | input | N | Second operand, unsigned |
| cin_i | input | 1 | Carry into the least significant bit |
| sum_o | output | N | Low N bits of the sum |
| cout_o | output | 1 | Carry out of the most significant bit |

## Verification
All results are due zero clock cycles after the stimulus, because the path from the inputs to sum_o and cout_o holds no register. Each directed task applies a vector, waits 1 ns so the combinational logic settles, and then compares against a sum that the bench computes itself. The clock does not align any sample. The next vector goes out only after the comparison, so every check sees the outputs of exactly one input set.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Candidate pair produced by one bit cell for both carry assumptions.
    typedef struct packed {
        logic s0;   // sum when carry-in is 0
        logic s1;   // sum when carry-in is 1
        logic c0;   // carry when carry-in is 0
        logic c1;   // carry when carry-in is 1
    } csa_cand_t;

endpackage

// File: rtl/csa_bit_cell.sv
module csa_bit_cell
    import csa_pkg::*;
(
    input  logic      a_i,
    input  logic      b_i,
    output csa_cand_t cand_o
);

    logic half_sum_w;
    logic half_carry_w;

    // Half-sum and half-carry generation.
    assign half_sum_w   = a_i ^ b_i;
    assign half_carry_w = a_i & b_i;

    // Full-sum and full-carry for both carry assumptions, sharing the half terms.
    always_comb begin
        cand_o.s0 = half_sum_w;
        cand_o.s1 = ~half_sum_w;
        cand_o.c0 = half_carry_w;
        cand_o.c1 = a_i | b_i;
    end

    // R4: each candidate pair matches the arithmetic one-bit sum.
    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            a_r4_cell_cin0: assert ({cand_o.c0, cand_o.s0} == ({1'b0, a_i} + {1'b0, b_i}))
                else $error("R4 cell carry-0 candidate wrong");
            a_r4_cell_cin1: assert ({cand_o.c1, cand_o.s1} == ({1'b0, a_i} + {1'b0, b_i} + 2'd1))
                else $error("R4 cell carry-1 candidate wrong");
        end
    end

endmodule

// File: rtl/csa_group.sv
module csa_group
    import csa_pkg::*;
#(
    parameter int G = 4
) (
    input  logic [G-1:0] a_i,
    input  logic [G-1:0] b_i,
    output logic [G-1:0] sum0_o,
    output logic [G-1:0] sum1_o,
    output logic         cout0_o,
    output logic         cout1_o
);

    // Two carry chains resolved bit by bit from the shared candidate pairs.
    logic [G:0] k0_w;
    logic [G:0] k1_w;

    assign k0_w[0] = 1'b0;
    assign k1_w[0] = 1'b1;

    for (genvar i = 0; i < G; i++) begin : g_bit
        csa_cand_t cand_w;

        csa_bit_cell u_cell (
            .a_i    (a_i[i]),
            .b_i    (b_i[i]),
            .cand_o (cand_w)
        );

        assign sum0_o[i]  = k0_w[i] ? cand_w.s1 : cand_w.s0;
        assign k0_w[i+1]  = k0_w[i] ? cand_w.c1 : cand_w.c0;
        assign sum1_o[i]  = k1_w[i] ? cand_w.s1 : cand_w.s0;
        assign k1_w[i+1]  = k1_w[i] ? cand_w.c1 : cand_w.c0;
    end

    assign cout0_o = k0_w[G];
    assign cout1_o = k1_w[G];

    // R5: both group candidates equal the slice sum with carry 0 and carry 1.
    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            a_r5_group_cin0: assert ({cout0_o, sum0_o} == ({1'b0, a_i} + {1'b0, b_i}))
                else $error("R5 group carry-0 candidate wrong");
            a_r5_group_cin1: assert ({cout1_o, sum1_o} == ({1'b0, a_i} + {1'b0, b_i} + (G+1)'(1)))
                else $error("R5 group carry-1 candidate wrong");
            a_r5_carry_order: assert (!cout0_o || cout1_o)
                else $error("R5 carry-0 carry-out set while carry-1 carry-out clear");
        end
    end

endmodule

// File: rtl/csa_adder.sv
module csa_adder
    import csa_pkg::*;
#(
    parameter int N = 8,
    parameter int G = 4
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         cin_i,
    output logic [N-1:0] sum_o,
    output logic         cout_o
);

    localparam int NG = N / G;

    // R7: the width must split into whole groups.
    if (G < 1 || (N % G) != 0) begin : g_bad_split
        $error("csa_adder: N must be a positive multiple of G");
    end

    // Selected carry entering each group; index NG is the final carry-out.
    logic [NG:0] sel_w;

    assign sel_w[0] = cin_i;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        logic [G-1:0] s0_w;
        logic [G-1:0] s1_w;
        logic         c0_w;
        logic         c1_w;

        csa_group #(.G(G)) u_group (
            .a_i     (a_i[g*G +: G]),
            .b_i     (b_i[g*G +: G]),
            .sum0_o  (s0_w),
            .sum1_o  (s1_w),
            .cout0_o (c0_w),
            .cout1_o (c1_w)
        );

        assign sum_o[g*G +: G] = sel_w[g] ? s1_w : s0_w;
        assign sel_w[g+1]      = sel_w[g] ? c1_w : c0_w;
    end

    assign cout_o = sel_w[NG];

    // R1 / R3: the selected result equals the behavioural sum.
    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i})) begin
            a_r1_total: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (N+1)'(cin_i)))
                else $error("R1 adder result wrong");
        end
    end

endmodule

// File: tb/test_csa_adder.sv
module test_csa_adder;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Default instance, N = 8, G = 4.
    logic [7:0]  a8, b8, s8;
    logic        c8, co8;
    csa_adder i_csa_adder (.a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8), .cout_o(co8));

    // N = 1, G = 1: exposes one bit cell at the ports.
    logic a1, b1, c1, s1, co1;
    csa_adder #(.N(1), .G(1)) i_csa_adder_n1 (.a_i(a1), .b_i(b1), .cin_i(c1), .sum_o(s1), .cout_o(co1));

    // N = 16, G = 4.
    logic [15:0] a16, b16, s16;
    logic        c16, co16;
    csa_adder #(.N(16), .G(4)) i_csa_adder_w16 (.a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16), .cout_o(co16));

    // N = 12, G = 3.
    logic [11:0] a12, b12, s12;
    logic        c12, co12;
    csa_adder #(.N(12), .G(3)) i_csa_adder_w12 (.a_i(a12), .b_i(b12), .cin_i(c12), .sum_o(s12), .cout_o(co12));

    // N = 8, G = 8 and N = 8, G = 1.
    logic [7:0]  sg8, sg1;
    logic        cog8, cog1;
    csa_adder #(.N(8), .G(8)) i_csa_adder_g8 (.a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(sg8), .cout_o(cog8));
    csa_adder #(.N(8), .G(1)) i_csa_adder_g1 (.a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(sg1), .cout_o(cog1));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic apply8(input logic [7:0] a, input logic [7:0] b, input logic c);
        a8 = a; b8 = b; c8 = c;
        #1;
    endtask

    // R8: all-zero inputs give a zero result at once.
    task automatic t_idle();
        apply8(8'h00, 8'h00, 1'b0);
        check("R8 zero inputs", {23'd0, co8, s8}, 32'd0);
        apply8(8'h01, 8'h02, 1'b0);
        check("R8 same-step update", {23'd0, co8, s8}, 32'd3);
    endtask

    // R1, R2 and R3: every operand pair with both carry-in values.
    task automatic t_exhaustive();
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                logic [8:0] r0;
                logic [8:0] r1;
                apply8(a[7:0], b[7:0], 1'b0);
                r0 = {co8, s8};
                check("R1 cin0", {23'd0, r0}, a + b);
                check("R3 cout cin0", {31'd0, co8}, {31'd0, (a + b) >= 256});
                apply8(a[7:0], b[7:0], 1'b1);
                r1 = {co8, s8};
                check("R1 cin1", {23'd0, r1}, a + b + 1);
                check("R2 plus one", {23'd0, r1}, {23'd0, r0 + 9'd1});
            end
        end
    endtask

    // R3 boundaries around 2^N.
    task automatic t_cout_edges();
        apply8(8'h80, 8'h7F, 1'b0);
        check("R3 just below", {31'd0, co8}, 32'd0);
        apply8(8'h80, 8'h7F, 1'b1);
        check("R3 exactly 256", {23'd0, co8, s8}, 32'h100);
        apply8(8'hFF, 8'hFF, 1'b1);
        check("R3 maximum", {23'd0, co8, s8}, 32'h1FF);
    endtask

    // R6: carries crossing group boundaries.
    task automatic t_ripple();
        apply8(8'hFF, 8'h00, 1'b1);
        check("R6 full chain", {23'd0, co8, s8}, 32'h100);
        apply8(8'h0F, 8'h01, 1'b0);
        check("R6 group boundary", {23'd0, co8, s8}, 32'h010);
        apply8(8'h0F, 8'h00, 1'b1);
        check("R6 boundary via cin", {23'd0, co8, s8}, 32'h010);
    endtask

    // R4: one bit cell through the N = 1 instance.
    task automatic t_cell();
        for (int v = 0; v < 4; v++) begin
            logic sa;
            a1 = v[1]; b1 = v[0]; c1 = 1'b0;
            #1;
            sa = s1;
            check("R4 cin0 sum", {31'd0, s1}, {31'd0, v[1] ^ v[0]});
            check("R4 cin0 carry", {31'd0, co1}, {31'd0, v[1] & v[0]});
            c1 = 1'b1;
            #1;
            check("R4 cin1 carry", {31'd0, co1}, {31'd0, v[1] | v[0]});
            check("R4 inverse sum", {31'd0, s1}, {31'd0, ~sa});
        end
    endtask

    // R5 / R7: other group splits and widths.
    task automatic t_params();
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] x;
            logic [31:0] y;
            logic        ci;
            x = $urandom; y = $urandom; ci = x[31] ^ y[31];
            a16 = x[15:0]; b16 = y[15:0]; c16 = ci;
            a12 = x[27:16]; b12 = y[27:16]; c12 = ci;
            a8 = x[23:16]; b8 = y[23:16]; c8 = ci;
            #1;
            check("R7 width16", {15'd0, co16, s16}, {16'd0, x[15:0]} + {16'd0, y[15:0]} + {31'd0, ci});
            check("R7 width12 groups3", {19'd0, co12, s12}, {20'd0, x[27:16]} + {20'd0, y[27:16]} + {31'd0, ci});
            check("R5 single group", {23'd0, cog8, sg8}, {24'd0, x[23:16]} + {24'd0, y[23:16]} + {31'd0, ci});
            check("R7 one-bit groups", {23'd0, cog1, sg1}, {24'd0, x[23:16]} + {24'd0, y[23:16]} + {31'd0, ci});
        end
    endtask

    initial begin
        a8 = '0; b8 = '0; c8 = 1'b0;
        a1 = 1'b0; b1 = 1'b0; c1 = 1'b0;
        a16 = '0; b16 = '0; c16 = 1'b0;
        a12 = '0; b12 = '0; c12 = 1'b0;
        @(negedge clk);
        t_idle();
        t_cout_edges();
        t_ripple();
        t_cell();
        t_params();
        t_exhaustive();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule